// File: doc/BRIEF.md
# Framed SPI Register Slave

This block lets an SPI master reach a bank of 16-bit registers. The bus runs with clock polarity and phase both 1: the line idles high, the slave moves its output after a falling edge, and both sides sample on the rising edge. Each chip-select frame carries exactly 16 bits in both directions at once.

The first bit of a frame chooses the direction. A write frame moves one byte to one 6-bit byte address. Each 16-bit register owns a lower-byte and an upper-byte address, so software writes a full register in two frames. A read frame names a byte address. The whole 16-bit register it belongs to comes back on the data output during the next frame, while the input of that frame already carries the following command. Read data is therefore pipelined by exactly one frame.

The serial pins are resampled into the system clock. The block gives the register bank a one-cycle write strobe with the byte address and byte data. It fetches read data with a one-cycle read strobe and a word index, and `rd_data` must be valid for that index in the cycle of the strobe. For the words chosen by `ND_MASK`, the block keeps a new-data flag per word. An update strobe from the data source sets the flag, a read clears it, and the flag replaces bit 15 of the returned word. A frame of the wrong length is dropped and raises `spi_err`.

Top module: `spi_regslave`

## Requirements
- R1: After reset, `spi_miso_oe`, `spi_err`, `wr_stb` and `rd_stb` are 0, every new-data flag is 0, and the data output shifts out sixteen zeros during the first frame.
- R2: A 16-clock frame whose first bit is 1 is a write. Frame bits 13:8 are the byte address and bits 7:0 the data, most significant bit first. Bit 14 is ignored, so both 10 and 11 prefixes write. After chip select rises, exactly one `wr_stb` pulse of one cycle carries that address and data.
- R3: A 16-clock frame whose first bit is 0 is a read, with either 00 or 01 as the prefix. It produces one `rd_stb` pulse with `rd_idx` equal to address bits 5:1, so both addresses of a pair select the same word. Bits 7:0 of the frame are ignored, and no write strobe occurs.
- R4: The word fetched by a read frame appears on the data output in the next frame, most significant bit first. That frame's input is decoded as a new command, so reads can be chained back to back.
- R5: Input is sampled on SCLK rising edges. The data output changes only after falling edges and stays stable while SCLK is high.
- R6: While chip select is high, `spi_miso_oe` is 0 and SCLK and MOSI activity causes no strobe and no change of `spi_err`.
- R7: A frame with other than 16 SCLK rising edges is discarded. It causes no strobe, sets `spi_err`, and makes the next frame shift out zeros. `spi_err` returns to 0 at the end of the next 16-clock frame.
- R8: For a word whose `ND_MASK` bit is 1, returned bit 15 is that word's new-data flag. `upd_stb` with `upd_idx` sets the flag, and reading the word clears it. For a word whose mask bit is 0, bit 15 comes from `rd_data`. Bits 14:0 always come from `rd_data`.
- R9: If an update and a read of the same flagged word fall in the same cycle, the returned bit 15 shows the flag value from before that cycle, and the flag ends set.
- R10: The frame following a write frame shifts out all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_cs_n | input | 1 | Chip select, active low, frames each transfer |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`; 0 means the pad floats |
| wr_stb | output | 1 | One-cycle byte write strobe |
| wr_addr | output | 6 | Byte address of the write |
| wr_data | output | 8 | Byte data of the write |
| rd_stb | output | 1 | One-cycle word fetch strobe |
| rd_idx | output | 5 | Word index of the fetch (byte address bits 5:1) |
| rd_data | input | 16 | Word contents for `rd_idx`, valid while `rd_stb` is high |
| upd_stb | input | 1 | New sample written to word `upd_idx` |
| upd_idx | input | 5 | Word index of the update |
| spi_err | output | 1 | Last frame had a wrong bit count |

## Verification
A read of a flagged word and a fresh update to that same word can land in the same system clock cycle. In that cycle one source clears the flag and the other sets it. The bench waits for the read strobe after a read frame and raises `upd_stb` for the same word in exactly that cycle. It then reads the word twice more. The first reply must show bit 15 set, which is the value from before the collision. The second reply must also show bit 15 set, because the update wins. A third read must show the flag clear.

// File: rtl/spi_regslave.sv
module spi_regslave #(
  parameter int          ADDR_W  = 6,
  parameter int          DATA_W  = 8,
  parameter logic [31:0] ND_MASK = 32'h0000_00FF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                spi_sclk,
  input  logic                spi_cs_n,
  input  logic                spi_mosi,
  output logic                spi_miso,
  output logic                spi_miso_oe,
  output logic                wr_stb,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [DATA_W-1:0]   wr_data,
  output logic                rd_stb,
  output logic [ADDR_W-2:0]   rd_idx,
  input  logic [2*DATA_W-1:0] rd_data,
  input  logic                upd_stb,
  input  logic [ADDR_W-2:0]   upd_idx,
  output logic                spi_err
);
  localparam int IDX_W      = ADDR_W - 1;
  localparam int NREG       = 1 << IDX_W;
  localparam int WORD_W     = 2 * DATA_W;
  localparam int FRAME_BITS = 2 + ADDR_W + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [NREG-1:0]  FLAGGED  = ND_MASK[NREG-1:0];

  logic [1:0] sclk_sy, cs_sy, mosi_sy;
  logic       sclk_d, cs_d;
  logic       active, miso_q;
  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] rx_sr;
  logic [WORD_W-1:0]     tx_sr, reply;
  logic [NREG-1:0]       nd, nd_next;

  wire sclk_rise = sclk_sy[1] & ~sclk_d;
  wire sclk_fall = ~sclk_sy[1] & sclk_d;
  wire cs_fall   = ~cs_sy[1] & cs_d;
  wire cs_rise   = cs_sy[1] & ~cs_d;
  wire frame_end = active & cs_rise;
  wire frame_ok  = frame_end & (bit_cnt == CNT_FULL);

  assign spi_miso_oe = active;
  assign spi_miso    = active & miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= 2'b11;
      cs_sy   <= 2'b11;
      mosi_sy <= 2'b00;
      sclk_d  <= 1'b1;
      cs_d    <= 1'b1;
    end else begin
      sclk_sy <= {sclk_sy[0], spi_sclk};
      cs_sy   <= {cs_sy[0], spi_cs_n};
      mosi_sy <= {mosi_sy[0], spi_mosi};
      sclk_d  <= sclk_sy[1];
      cs_d    <= cs_sy[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      miso_q  <= 1'b0;
    end else if (cs_fall) begin
      active  <= 1'b1;
      bit_cnt <= '0;
      miso_q  <= reply[WORD_W-1];
      tx_sr   <= {reply[WORD_W-2:0], 1'b0};
    end else if (cs_rise) begin
      active  <= 1'b0;
    end else if (active) begin
      if (sclk_rise) begin
        rx_sr <= {rx_sr[FRAME_BITS-2:0], mosi_sy[1]};
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
      end
      if (sclk_fall && bit_cnt != '0) begin
        miso_q <= tx_sr[WORD_W-1];
        tx_sr  <= {tx_sr[WORD_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      rd_stb  <= 1'b0;
      rd_idx  <= '0;
      spi_err <= 1'b0;
    end else begin
      wr_stb <= frame_ok & rx_sr[FRAME_BITS-1];
      rd_stb <= frame_ok & ~rx_sr[FRAME_BITS-1];
      if (frame_ok) begin
        wr_addr <= rx_sr[FRAME_BITS-3 -: ADDR_W];
        wr_data <= rx_sr[DATA_W-1:0];
        rd_idx  <= rx_sr[FRAME_BITS-3 -: IDX_W];
      end
      if (frame_end) spi_err <= ~frame_ok;
    end
  end

  always_comb begin
    nd_next = nd;
    if (rd_stb && FLAGGED[rd_idx]) nd_next[rd_idx] = 1'b0;
    if (upd_stb && FLAGGED[upd_idx]) nd_next[upd_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nd    <= '0;
      reply <= '0;
    end else begin
      nd <= nd_next;
      if (rd_stb)
        reply <= {FLAGGED[rd_idx] ? nd[rd_idx] : rd_data[WORD_W-1], rd_data[WORD_W-2:0]};
      else if (frame_end && !(frame_ok && !rx_sr[FRAME_BITS-1]))
        reply <= '0;
    end
  end
endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk (
  input logic clk,
  input logic rst_n,
  input logic spi_cs_n,
  input logic spi_miso_oe,
  input logic wr_stb,
  input logic rd_stb,
  input logic spi_err
);
  a_r6_oe_off_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso_oe);

  a_r2_wr_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  a_r3_rd_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb);

  a_r3_no_wr_with_rd: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && rd_stb));

  a_r7_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_err) |-> (!wr_stb && !rd_stb));
endmodule

bind spi_regslave spi_regslave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso_oe(spi_miso_oe),
  .wr_stb(wr_stb), .rd_stb(rd_stb), .spi_err(spi_err)
);

// File: tb/spi_regslave_tb.sv
module spi_regslave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
  logic upd_stb = 1'b0;
  logic [4:0] upd_idx = '0;
  logic miso, miso_oe, wr_stb, rd_stb, spi_err;
  logic [5:0] wr_addr;
  logic [7:0] wr_data;
  logic [4:0] rd_idx;
  logic [15:0] rd_data;

  int checks = 0, fails = 0, r5_bad = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [5:0] lw_addr = '0;
  logic [7:0] lw_data = '0;
  logic [4:0] lr_idx = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] bank(input logic [4:0] i);
    return {i, i, i, 1'b1};
  endfunction
  assign rd_data = bank(rd_idx);

  spi_regslave u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_stb(rd_stb), .rd_idx(rd_idx), .rd_data(rd_data),
    .upd_stb(upd_stb), .upd_idx(upd_idx), .spi_err(spi_err)
  );

  always @(posedge clk) begin
    if (wr_stb) begin wr_cnt <= wr_cnt + 1; lw_addr <= wr_addr; lw_data <= wr_data; end
    if (rd_stb) begin rd_cnt <= rd_cnt + 1; lr_idx <= rd_idx; end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] rd_cmd(input logic [5:0] a);
    return {2'b00, a, 8'h00};
  endfunction
  function automatic logic [15:0] wr_cmd(input logic [5:0] a, input logic [7:0] d);
    return {2'b10, a, d};
  endfunction

  task automatic frame(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
    logic b;
    rx = '0;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      mosi = (i < 16) ? tx[15-i] : 1'b0;
      wait_clk(HALF);
      b = miso;
      if (i < 16) rx[15-i] = b;
      sclk = 1'b1;
      wait_clk(HALF);
      if (miso !== b) r5_bad++;
    end
    cs_n = 1'b1;
    wait_clk(12);
  endtask

  task automatic pulse_upd(input logic [4:0] i);
    upd_idx = i; upd_stb = 1'b1;
    wait_clk(1);
    upd_stb = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] rx;
    chk(miso_oe == 1'b0, "R1 oe after reset", 32'(miso_oe), 0);
    chk(spi_err == 1'b0, "R1 err after reset", 32'(spi_err), 0);
    chk(!wr_stb && !rd_stb, "R1 strobes after reset", 32'({wr_stb, rd_stb}), 0);
    frame(rd_cmd(6'h04), 16, rx);
    chk(rx == 16'h0000, "R1 first frame zeros", 32'(rx), 0);
    chk(rd_cnt == 1 && lr_idx == 5'd2, "R3 read strobe idx", 32'(lr_idx), 2);
  endtask

  task automatic t_new_data;
    logic [15:0] rx;
    pulse_upd(5'd2);
    frame(rd_cmd(6'h05), 16, rx);
    chk(rx == {1'b0, bank(2)[14:0]}, "R8 flag clear from reset", 32'(rx), 32'({1'b0, bank(2)[14:0]}));
    chk(lr_idx == 5'd2, "R3 upper address same word", 32'(lr_idx), 2);
    frame(rd_cmd(6'h04), 16, rx);
    chk(rx == {1'b1, bank(2)[14:0]}, "R8 flag set by update", 32'(rx), 32'({1'b1, bank(2)[14:0]}));
    frame(rd_cmd(6'h21), 16, rx);
    chk(rx == {1'b0, bank(2)[14:0]}, "R8 flag cleared by read", 32'(rx), 32'({1'b0, bank(2)[14:0]}));
    frame({2'b00, 6'h3F, 8'hFF}, 16, rx);
    chk(rx == bank(16), "R8 unflagged word bit15 passthrough", 32'(rx), 32'(bank(16)));
    chk(lr_idx == 5'd31 && wr_cnt == 0, "R3 tail bits ignored", 32'(lr_idx), 31);
  endtask

  task automatic t_write;
    logic [15:0] rx;
    int w0;
    w0 = wr_cnt;
    frame(wr_cmd(6'h2A, 8'hC3), 16, rx);
    chk(wr_cnt == w0 + 1 && lw_addr == 6'h2A && lw_data == 8'hC3, "R2 write 10",
        32'({lw_addr, lw_data}), 32'({6'h2A, 8'hC3}));
    frame({2'b11, 6'h15, 8'h3C}, 16, rx);
    chk(rx == 16'h0000, "R10 zeros after write", 32'(rx), 0);
    chk(wr_cnt == w0 + 2 && lw_addr == 6'h15 && lw_data == 8'h3C, "R2 write 11",
        32'({lw_addr, lw_data}), 32'({6'h15, 8'h3C}));
    frame({2'b01, 6'h0D, 8'h00}, 16, rx);
    chk(rx == 16'h0000, "R10 zeros after 11 write", 32'(rx), 0);
    chk(wr_cnt == w0 + 2 && lr_idx == 5'd6, "R3 prefix 01 reads", 32'(lr_idx), 6);
  endtask

  task automatic t_pipeline;
    logic [15:0] rx;
    frame(rd_cmd(6'h0A), 16, rx);
    frame(rd_cmd(6'h0C), 16, rx);
    chk(rx == bank(5) & 16'h7FFF, "R4 chained word 5", 32'(rx), 32'(bank(5) & 16'h7FFF));
    frame(wr_cmd(6'h30, 8'h11), 16, rx);
    chk(rx == bank(6) & 16'h7FFF, "R4 chained word 6", 32'(rx), 32'(bank(6) & 16'h7FFF));
    chk(lw_addr == 6'h30 && lw_data == 8'h11, "R4 command decoded during reply",
        32'({lw_addr, lw_data}), 32'({6'h30, 8'h11}));
  endtask

  task automatic t_bad_length;
    logic [15:0] rx;
    int w0, r0;
    frame(rd_cmd(6'h0A), 16, rx);
    w0 = wr_cnt; r0 = rd_cnt;
    frame(wr_cmd(6'h01, 8'hAA), 12, rx);
    chk(spi_err == 1'b1, "R7 short frame err", 32'(spi_err), 1);
    chk(wr_cnt == w0 && rd_cnt == r0, "R7 short frame dropped", 32'(wr_cnt - w0), 0);
    frame(rd_cmd(6'h08), 16, rx);
    chk(rx == 16'h0000, "R7 zeros after bad frame", 32'(rx), 0);
    chk(spi_err == 1'b0, "R7 err cleared by good frame", 32'(spi_err), 0);
    r0 = rd_cnt;
    frame(rd_cmd(6'h08), 18, rx);
    chk(spi_err == 1'b1 && rd_cnt == r0, "R7 long frame err", 32'(spi_err), 1);
  endtask

  task automatic t_idle;
    int w0, r0, oe_bad;
    logic e0;
    w0 = wr_cnt; r0 = rd_cnt; e0 = spi_err; oe_bad = 0;
    for (int i = 0; i < 24; i++) begin
      sclk = ~sclk;
      mosi = i[1];
      wait_clk(3);
      if (miso_oe) oe_bad++;
    end
    sclk = 1'b1;
    wait_clk(8);
    chk(oe_bad == 0, "R6 oe stays low", 32'(oe_bad), 0);
    chk(wr_cnt == w0 && rd_cnt == r0 && spi_err == e0, "R6 idle activity ignored",
        32'(wr_cnt - w0 + rd_cnt - r0), 0);
  endtask

  task automatic t_collide;
    logic [15:0] rx;
    pulse_upd(5'd3);
    fork
      frame(rd_cmd(6'h06), 16, rx);
      begin
        do @(negedge clk); while (!rd_stb);
        upd_idx = 5'd3; upd_stb = 1'b1;
        @(negedge clk);
        upd_stb = 1'b0;
      end
    join
    frame(rd_cmd(6'h07), 16, rx);
    chk(rx == {1'b1, bank(3)[14:0]}, "R9 reply shows prior flag", 32'(rx), 32'({1'b1, bank(3)[14:0]}));
    frame(rd_cmd(6'h06), 16, rx);
    chk(rx == {1'b1, bank(3)[14:0]}, "R9 update wins", 32'(rx), 32'({1'b1, bank(3)[14:0]}));
    frame(wr_cmd(6'h3A, 8'h00), 16, rx);
    chk(rx == {1'b0, bank(3)[14:0]}, "R9 flag cleared afterwards", 32'(rx), 32'({1'b0, bank(3)[14:0]}));
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_new_data();
    t_write();
    t_pipeline();
    t_bad_length();
    t_idle();
    t_collide();
    chk(r5_bad == 0, "R5 output stable while SCLK high", 32'(r5_bad), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule